// File: doc/BRIEF.md
# Qualified Pickup Delay Timer

This block confirms that a trip request is genuine before it is passed to the next stage. A request counts as qualified only while it is high and all three blocking inputs (inhibit, block and guard) are low. While the request stays qualified, the block counts tick-enable pulses. Once the count reaches a programmable pickup value, the block raises its pre-trip output. That output goes to a later noise-qualification stage and does not drive any trip outputs itself.

The count starts again from zero whenever the request drops or any blocker becomes active. A short burst of noise on the request line therefore never builds up toward a trip. All inputs pass through one synchronous sampling register. The output is a plain flip-flop, so it cannot glitch.

Top module: `pickup_qual_timer`

## Requirements
- R1: While `rst_n` is low, and after its release until a request has qualified, `pre_trip` is 0.
- R2: `trip_req` is active high. When `trip_req` is low at the edge that samples it, `pre_trip` is 0 after the following edge.
- R3: A high level on any one of `inhibit`, `block_in` or `guard` disqualifies the request. `pre_trip` is 0 after the edge that follows the sampling edge, and the tick count clears to zero.
- R4: With a pickup value N > 0, `pre_trip` rises at the edge after the sampling edge that captures the N-th `tick_en` pulse sampled during one unbroken qualified interval. With one tick every cycle, `pre_trip` is high after the (N+1)-th edge counted from the first sampling edge.
- R5: When the request drops and then returns, a full N ticks are needed again. Ticks from before the drop are not counted.
- R6: A pickup value of 0 makes `pre_trip` high after the second edge from the one that samples a qualified request, whatever `tick_en` is doing.
- R7: The pickup value is taken at the first cycle of a qualified interval. A change to `pickup_cnt` while counting has no effect until the next qualified interval.
- R8: Once `pre_trip` is high, it stays high for as long as the request stays qualified, with or without ticks.
- R9: Cycles with `tick_en` low do not advance the count.
- R10: The largest pickup value (all ones) is reached exactly, with no wrap of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Time-base pulse that advances the pickup count |
| trip_req | input | 1 | Trip request, active high |
| inhibit | input | 1 | Blocking condition, active high |
| block_in | input | 1 | Blocking condition, active high |
| guard | input | 1 | Blocking condition, active high |
| pickup_cnt | input | CNT_W | Pickup interval in tick units |
| pre_trip | output | 1 | Qualified pre-trip output, registered |

## Verification
The bench builds the timer with `CNT_W = 4` and the default `IN_REG = 1`. The 4-bit counter makes the all-ones pickup value of 15 short enough to reach in a directed run and often enough under random stimulus, so counter saturation and the exact-match compare at the top of the range both get exercised. Because random pickup values are limited to 0..15, value 0, value 1 and mid-count changes of the pickup value all come up often, alongside blocker pulses that land inside partly finished counts.

// File: rtl/pqt_pkg.sv
// Package: shared types for the qualified pickup delay timer.
// Assumes: nothing beyond IEEE 1800-2017.
package pqt_pkg;

    // Control states of the pickup sequencer.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_PICKED = 2'd2
    } pqt_state_t;

endpackage

// File: rtl/pqt_sampler.sv
// Module: pqt_sampler
// Takes the request, the three blockers, the tick and the pickup value into
// the clock domain. Forms the combined "qualified" term from the sampled bits.
// Assumes: all inputs are already synchronous to clk. IN_REG=0 bypasses the
// stage and is meant only for parents that register these inputs themselves.
module pqt_sampler #(
    parameter int CNT_W  = 16,
    parameter int IN_REG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_req,
    input  logic             inhibit,
    input  logic             block_in,
    input  logic             guard,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] pickup_cnt,
    output logic             qual_s,
    output logic             tick_s,
    output logic [CNT_W-1:0] pk_s
);
    localparam int NBLK = 3;

    logic            req_r;
    logic [NBLK-1:0] blk_r;
    logic            tick_r;
    logic [CNT_W-1:0] pk_r;

    generate
        if (IN_REG != 0) begin : g_reg
            // Purpose: one synchronous sampling stage for every input.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    req_r  <= 1'b0;
                    blk_r  <= '0;
                    tick_r <= 1'b0;
                    pk_r   <= '0;
                end else begin
                    req_r  <= trip_req;
                    blk_r  <= {guard, block_in, inhibit};
                    tick_r <= tick_en;
                    pk_r   <= pickup_cnt;
                end
            end
        end else begin : g_bypass
            // Purpose: pass-through when the parent already registers inputs.
            always_comb begin
                req_r  = trip_req;
                blk_r  = {guard, block_in, inhibit};
                tick_r = tick_en;
                pk_r   = pickup_cnt;
            end
        end
    endgenerate

    // Purpose: request counts only while no blocker is active.
    always_comb begin
        qual_s = req_r && (blk_r == '0);
        tick_s = tick_r;
        pk_s   = pk_r;
    end

endmodule

// File: rtl/pqt_counter.sv
// Module: pqt_counter
// Tick counter for the pickup interval. Clear wins over increment. The counter
// holds at all ones instead of wrapping.
// Assumes: the controller never asks for an increment beyond the pickup value.
module pqt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Purpose: clear, advance or hold the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pqt_ctrl.sv
// Module: pqt_ctrl
// Pickup sequencer. Takes the pickup value at the start of a qualified
// interval, drives the counter and registers the pre-trip output.
// Assumes: cnt_q is zero whenever the sequencer is idle, because the counter
// is cleared on every unqualified cycle.
module pqt_ctrl
    import pqt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual_s,
    input  logic             tick_s,
    input  logic [CNT_W-1:0] pk_s,
    input  logic [CNT_W-1:0] cnt_q,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output pqt_state_t       state_q,
    output logic [CNT_W-1:0] hold_q,
    output logic             out_q
);
    localparam int EXT_W = CNT_W + 1;

    pqt_state_t       state_d;
    logic [CNT_W-1:0] lim;
    logic [EXT_W-1:0] cnt_next;
    logic             reach;

    // Purpose: choose the active limit and test whether this cycle completes it.
    always_comb begin
        lim      = (state_q == ST_IDLE) ? pk_s : hold_q;
        cnt_next = {1'b0, cnt_q} + EXT_W'(1);
        reach    = (lim == '0) || (tick_s && (cnt_next >= {1'b0, lim}));
    end

    // Purpose: next-state decision of the pickup sequencer.
    always_comb begin
        state_d = state_q;
        if (!qual_s) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE, ST_COUNT: state_d = reach ? ST_PICKED : ST_COUNT;
                ST_PICKED:         state_d = ST_PICKED;
                default:           state_d = ST_IDLE;
            endcase
        end
    end

    // Purpose: counter control, clearing on any unqualified cycle.
    always_comb begin
        cnt_clr = !qual_s;
        cnt_inc = qual_s && tick_s && (state_q != ST_PICKED);
    end

    // Purpose: state, captured limit and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                hold_q <= pk_s;
            end
            out_q <= (state_d == ST_PICKED);
        end
    end

endmodule

// File: rtl/pickup_qual_timer.sv
// Module: pickup_qual_timer (top)
// Qualified pickup delay timer. The request must stay high, with inhibit,
// block and guard all low, for pickup_cnt tick pulses before pre_trip rises.
// Any break in qualification clears the count.
// Assumes: synchronous inputs and a synchronous active-low reset.
module pickup_qual_timer
    import pqt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int IN_REG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             trip_req,
    input  logic             inhibit,
    input  logic             block_in,
    input  logic             guard,
    input  logic [CNT_W-1:0] pickup_cnt,
    output logic             pre_trip
);
    logic             qual_s;
    logic             tick_s;
    logic [CNT_W-1:0] pk_s;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_clr;
    logic             cnt_inc;
    pqt_state_t       state_q;
    logic [CNT_W-1:0] hold_q;
    logic             out_q;

    pqt_sampler #(.CNT_W(CNT_W), .IN_REG(IN_REG)) u_samp (
        .clk(clk), .rst_n(rst_n),
        .trip_req(trip_req), .inhibit(inhibit), .block_in(block_in),
        .guard(guard), .tick_en(tick_en), .pickup_cnt(pickup_cnt),
        .qual_s(qual_s), .tick_s(tick_s), .pk_s(pk_s)
    );

    pqt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(cnt_clr), .inc(cnt_inc), .cnt_q(cnt_q)
    );

    pqt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .qual_s(qual_s), .tick_s(tick_s), .pk_s(pk_s), .cnt_q(cnt_q),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .state_q(state_q), .hold_q(hold_q), .out_q(out_q)
    );

    // Purpose: expose the registered output.
    assign pre_trip = out_q;

endmodule

// File: rtl/pqt_checker.sv
// Module: pqt_checker
// Property checks for pickup_qual_timer, attached by bind below.
// Assumes: IN_REG = 1 (one sampling stage) for the port-level latencies.
module pqt_checker
    import pqt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trip_req,
    input logic             inhibit,
    input logic             block_in,
    input logic             guard,
    input logic             pre_trip,
    input logic             qual_s,
    input logic [CNT_W-1:0] pk_s,
    input logic [CNT_W-1:0] cnt_q,
    input pqt_state_t       state_q,
    input logic [CNT_W-1:0] hold_q
);
    // R1: output low during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_low_R1: assert (pre_trip == 1'b0 || $past(rst_n) == 1'b1);
        end
    end

    // R2: a low request at the input clears the output two edges later
    assert_req_low_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_req |=> ##1 !pre_trip);

    // R3: any blocker clears the output two edges later
    assert_blocker_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit || block_in || guard) |=> ##1 !pre_trip);

    // R3: an unqualified cycle leaves the counter at zero
    assert_unqual_clears_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_s |=> (cnt_q == '0));

    // R6: zero pickup value on a fresh qualified cycle raises the output
    assert_zero_pickup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && qual_s && pk_s == '0) |=> pre_trip);

    // R7: the captured limit does not move while counting
    assert_limit_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |=> $stable(hold_q));

    // R8: output stays high while still qualified
    assert_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_trip && qual_s) |=> pre_trip);

    // R10: count stays below the captured limit while counting, so no wrap
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q < hold_q));

endmodule

bind pickup_qual_timer pqt_checker #(.CNT_W(CNT_W)) u_pqt_chk (
    .clk(clk), .rst_n(rst_n), .trip_req(trip_req), .inhibit(inhibit),
    .block_in(block_in), .guard(guard), .pre_trip(pre_trip),
    .qual_s(qual_s), .pk_s(pk_s), .cnt_q(cnt_q), .state_q(state_q),
    .hold_q(hold_q)
);

// File: tb/test_pickup_qual_timer.sv
// Bench for pickup_qual_timer: directed corners plus seeded random stimulus,
// compared every cycle against a behavioural model kept in the bench.
module test_pickup_qual_timer;
    localparam int CNT_W = 4;
    localparam int WDOG  = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             trip_req = 1'b0;
    logic             inhibit = 1'b0;
    logic             block_in = 1'b0;
    logic             guard = 1'b0;
    logic [CNT_W-1:0] pickup_cnt = '0;
    logic             pre_trip;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    // Model state: sampled inputs and sequencer.
    bit               s_req, s_inh, s_blk, s_grd, s_tick;
    logic [CNT_W-1:0] s_pk;
    bit               m_idle = 1;
    bit               m_out = 0;
    int               m_cnt = 0;
    int               m_hold = 0;

    pickup_qual_timer #(.CNT_W(CNT_W), .IN_REG(1)) i_pickup_qual_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .trip_req(trip_req),
        .inhibit(inhibit), .block_in(block_in), .guard(guard),
        .pickup_cnt(pickup_cnt), .pre_trip(pre_trip)
    );

    always #10 clk = ~clk;

    // Advance the model by one clock edge using the values the design samples now.
    task automatic model_step();
        bit q;
        q = s_req && !s_inh && !s_blk && !s_grd;
        if (!rst_n) begin
            m_idle = 1; m_out = 0; m_cnt = 0; m_hold = 0;
        end else if (!q) begin
            m_idle = 1; m_out = 0; m_cnt = 0;
        end else if (!m_out) begin
            if (m_idle) begin
                m_hold = int'(s_pk);
                m_idle = 0;
            end
            if (m_hold == 0) m_out = 1;
            else if (s_tick) begin
                m_cnt++;
                if (m_cnt >= m_hold) m_out = 1;
            end
        end
        if (!rst_n) begin
            s_req = 0; s_inh = 0; s_blk = 0; s_grd = 0; s_tick = 0; s_pk = '0;
        end else begin
            s_req = trip_req; s_inh = inhibit; s_blk = block_in;
            s_grd = guard; s_tick = tick_en; s_pk = pickup_cnt;
        end
    endtask

    function automatic bit expect_out();
        return m_out;
    endfunction

    task automatic check(string req, bit act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: pre_trip=%0b expected %0b", req, cyc, act, exp);
        end
    endtask

    // One clock: edge, model update, compare just after the edge.
    task automatic step(string req);
        @(posedge clk);
        #1;
        cyc++;
        model_step();
        check(req, pre_trip, expect_out());
    endtask

    task automatic set_in(bit r, bit i, bit b, bit g, bit t, int pk);
        trip_req = r; inhibit = i; block_in = b; guard = g; tick_en = t;
        pickup_cnt = CNT_W'(pk);
    endtask

    // Count edges until pre_trip rises, with tick every cycle.
    task automatic edges_to_rise(string req, int pk, int exp_edges);
        int n;
        n = 0;
        set_in(1, 0, 0, 0, 1, pk);
        while (pre_trip !== 1'b1 && n < 40) begin
            step(req);
            n++;
        end
        total++;
        if (n != exp_edges) begin
            bad++;
            $display("FAIL %s rise after %0d edges expected %0d", req, n, exp_edges);
        end
    endtask

    task automatic idle_cycles(int n);
        set_in(0, 0, 0, 0, 0, int'(pickup_cnt));
        for (int k = 0; k < n; k++) step("R2");
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        #(WDOG * 20);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2468));
        // R1: reset
        for (int k = 0; k < 3; k++) step("R1");
        set_in(1, 0, 0, 0, 1, 2);
        step("R1");
        rst_n = 1'b1;
        set_in(0, 0, 0, 0, 0, 2);
        for (int k = 0; k < 3; k++) step("R1");
        check("R1", pre_trip, 1'b0);

        // R4: pickup 3, tick each cycle -> high after 4 edges
        edges_to_rise("R4", 3, 4);
        // R8: stays high while qualified, ticks or not
        for (int k = 0; k < 6; k++) begin
            tick_en = k[0];
            step("R8");
        end
        check("R8", pre_trip, 1'b1);
        idle_cycles(3);

        // R6: pickup 0 -> high after 2 edges
        edges_to_rise("R6", 0, 2);
        idle_cycles(3);
        // R4: pickup 1 -> high after 2 edges
        edges_to_rise("R4", 1, 2);
        idle_cycles(3);

        // R9: ticks every other cycle, pickup 3
        set_in(1, 0, 0, 0, 0, 3);
        for (int k = 0; k < 8; k++) begin
            tick_en = k[0];
            step("R9");
        end
        idle_cycles(3);

        // R3: each blocker mid-count, then full count needed again
        for (int b = 0; b < 3; b++) begin
            set_in(1, 0, 0, 0, 1, 4);
            for (int k = 0; k < 3; k++) step("R3");
            set_in(1, b == 0, b == 1, b == 2, 1, 4);
            step("R3");
            set_in(1, 0, 0, 0, 1, 4);
            for (int k = 0; k < 3; k++) step("R3");
            check("R3", pre_trip, 1'b0);
            for (int k = 0; k < 3; k++) step("R3");
            check("R3", pre_trip, 1'b1);
            set_in(1, b == 0, b == 1, b == 2, 1, 4);
            step("R3");
            step("R3");
            check("R3", pre_trip, 1'b0);
        end
        idle_cycles(3);

        // R5: drop one cycle mid-count
        set_in(1, 0, 0, 0, 1, 5);
        for (int k = 0; k < 4; k++) step("R5");
        trip_req = 0;
        step("R5");
        trip_req = 1;
        for (int k = 0; k < 5; k++) step("R5");
        check("R5", pre_trip, 1'b0);
        for (int k = 0; k < 2; k++) step("R5");
        check("R5", pre_trip, 1'b1);
        idle_cycles(3);

        // R7: pickup raised to 15 mid-count is ignored
        set_in(1, 0, 0, 0, 1, 3);
        step("R7");
        pickup_cnt = 4'd15;
        for (int k = 0; k < 3; k++) step("R7");
        check("R7", pre_trip, 1'b1);
        idle_cycles(3);
        // R7: pickup lowered to 1 mid-count is ignored
        set_in(1, 0, 0, 0, 1, 6);
        step("R7");
        pickup_cnt = 4'd1;
        for (int k = 0; k < 4; k++) step("R7");
        check("R7", pre_trip, 1'b0);
        idle_cycles(3);

        // R10: all-ones pickup -> high after 16 edges
        edges_to_rise("R10", 15, 16);
        idle_cycles(3);

        // R2: random stimulus
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 19) == 0) trip_req = ~trip_req;
            else if ($urandom_range(0, 3) != 0 && !trip_req) trip_req = 1'b1;
            inhibit  = ($urandom_range(0, 39) == 0);
            block_in = ($urandom_range(0, 39) == 0);
            guard    = ($urandom_range(0, 39) == 0);
            tick_en  = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 15) == 0) pickup_cnt = CNT_W'($urandom_range(0, 15));
            step("R2");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule